// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It looks up two tables held in memory: first a page directory, then a page table. Each table takes up one 4KB page and holds 1024 entries of 4 bytes. The linear address is cut into three fields:

- the upper ten bits pick a directory entry;
- the middle ten bits pick an entry in the page table that the directory entry points to;
- the lower twelve bits are the byte offset inside the 4KB page that the table entry names.

The block reads each entry through a single 32-bit memory read port. That port uses a level request and a one-cycle acknowledge that carries the data.

A client raises a request strobe with a linear address. It also supplies a paging-enable bit and the directory base. The walker accepts one request at a time. When the walk ends, it pulses either a done strobe with the physical address or a fault strobe with the faulting linear address and the page-fault vector. The results stay on the outputs until the next request is accepted. When paging is off, the address goes straight through without any memory traffic.

Top module: `ptw_walker`

## Requirements
- R1: The first memory read of a paged walk goes to address {dir_base[31:12], lin[31:22], 2'b00}. The low twelve bits of dir_base have no effect.
- R2: If the directory entry has bit 0 (present) set, a second read goes to {dir_entry[31:12], lin[21:12], 2'b00}.
- R3: If the table entry has bit 0 set, xl_done pulses and xl_phys = {tbl_entry[31:12], lin[11:0]}. Bits 11:1 of both entries have no effect on the result.
- R4: A directory entry with bit 0 clear ends the walk after exactly one read, with no page-table read, and raises xl_fault in the cycle after the acknowledge.
- R5: A table entry with bit 0 clear ends the walk after exactly two reads with xl_fault.
- R6: With pg_en low at acceptance, xl_done pulses in the next cycle with xl_phys equal to the linear address, and no memory read is made.
- R7: During the xl_fault pulse, xl_fault_addr holds the faulting linear address and fault_vec is 14. fault_vec is 0 at all other times, and xl_done never rises together with xl_fault.
- R8: mem_req stays high with mem_addr unchanged until mem_ack arrives, whatever the memory latency.
- R9: While a walk is in progress, req_valid is ignored. pg_en, dir_base and the linear address are captured when the request is accepted, so later changes to them have no effect on that walk.
- R10: xl_done and xl_fault each last exactly one cycle, and each walk gives exactly one of them. xl_phys and xl_fault_addr hold their values until the next request is accepted.
- R11: After reset, mem_req, xl_done, xl_fault, fault_vec, xl_phys and xl_fault_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_lin | input | 32 | Linear address to translate |
| pg_en | input | 1 | Paging enable; low means pass-through |
| dir_base | input | 32 | Page directory base (bits 31:12 used) |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read acknowledge, one cycle, data valid |
| mem_rdata | input | 32 | Read data |
| xl_done | output | 1 | One-cycle pulse: translation complete |
| xl_phys | output | 32 | Physical address of the last successful walk |
| xl_fault | output | 1 | One-cycle pulse: page fault |
| xl_fault_addr | output | 32 | Linear address of the last fault |
| fault_vec | output | 8 | Exception vector, 14 during a fault pulse |

## Verification
The bench goes through directory and table indices from 0 to 1023 and through many page offsets, and it varies the memory latency from zero to three wait cycles. It checks the exact addresses that are read. A design that read the page table after a non-present directory entry would show one read too many. A design that used the directory entry's flag bits, or the low bits of the base, in the table address would read the wrong location. The bench also changes dir_base, pg_en and the request address in the middle of a walk, and re-raises the request strobe while the walker is busy. A walker that sampled those inputs late would produce a wrong physical address, and one that restarted would produce a second completion pulse. Pass-through requests check that the linear address comes back one cycle later with no read. A design that dropped mem_req or changed the address during wait cycles would break the read sequence the bench expects.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Walk phases
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DIR   = 3'd1,
    ST_TBL   = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } walk_state_e;

  // Bit of each entry that marks it valid
  localparam int unsigned PRESENT_BIT = 0;
  // Vector reported with a missing-page fault
  localparam logic [7:0] PF_VECTOR = 8'd14;
endpackage

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        pg_en,
  input  logic        mem_ack,
  input  logic        ent_present,
  output walk_state_e state,
  output logic        take_req,
  output logic        take_pde,
  output logic        take_pte,
  output logic        take_fault
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    take_req   = 1'b0;
    take_pde   = 1'b0;
    take_pte   = 1'b0;
    take_fault = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          take_req = 1'b1;
          state_d  = pg_en ? ST_DIR : ST_DONE;
        end
      end
      ST_DIR: begin
        if (mem_ack) begin
          if (ent_present) begin
            take_pde = 1'b1;
            state_d  = ST_TBL;
          end else begin
            take_fault = 1'b1;
            state_d    = ST_FAULT;
          end
        end
      end
      ST_TBL: begin
        if (mem_ack) begin
          if (ent_present) begin
            take_pte = 1'b1;
            state_d  = ST_DONE;
          end else begin
            take_fault = 1'b1;
            state_d    = ST_FAULT;
          end
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         req_lin,
  input  logic [ADDR_W-OFF_W-1:0]   base_frame,
  input  logic [ADDR_W-OFF_W-1:0]   rd_frame,
  input  logic                      pg_en,
  input  logic                      take_req,
  input  logic                      take_pde,
  input  logic                      take_pte,
  input  logic                      take_fault,
  input  logic                      sel_tbl,
  output logic [ADDR_W-1:0]         rd_addr,
  output logic [ADDR_W-1:0]         phys,
  output logic [ADDR_W-1:0]         flt_addr
);
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;
  localparam int unsigned IDX_W   = FRAME_W / 2;
  localparam int unsigned ENT_SH  = OFF_W - IDX_W;
  localparam int unsigned DIR_LO  = OFF_W + IDX_W;

  logic [ADDR_W-1:0]  lin_q, lin_d;
  logic [FRAME_W-1:0] base_q, base_d;
  logic [FRAME_W-1:0] pde_q, pde_d;
  logic [ADDR_W-1:0]  phys_q, phys_d;
  logic [ADDR_W-1:0]  flt_q, flt_d;

  logic en_lin, en_pde, en_phys, en_flt;

  always_comb begin
    en_lin  = take_req;
    lin_d   = req_lin;
    base_d  = base_frame;
    en_pde  = take_pde;
    pde_d   = rd_frame;
    en_phys = (take_req && !pg_en) || take_pte;
    phys_d  = take_req ? req_lin : {rd_frame, lin_q[OFF_W-1:0]};
    en_flt  = take_fault;
    flt_d   = lin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q  <= '0;
      base_q <= '0;
      pde_q  <= '0;
      phys_q <= '0;
      flt_q  <= '0;
    end else begin
      if (en_lin) begin
        lin_q  <= lin_d;
        base_q <= base_d;
      end
      if (en_pde)  pde_q  <= pde_d;
      if (en_phys) phys_q <= phys_d;
      if (en_flt)  flt_q  <= flt_d;
    end
  end

  // Entry address: table frame, then index scaled by entry size
  always_comb begin
    if (sel_tbl) rd_addr = {pde_q,  lin_q[DIR_LO-1:OFF_W],  {ENT_SH{1'b0}}};
    else         rd_addr = {base_q, lin_q[ADDR_W-1:DIR_LO], {ENT_SH{1'b0}}};
  end

  assign phys     = phys_q;
  assign flt_addr = flt_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic              pg_en,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              xl_done,
  output logic [ADDR_W-1:0] xl_phys,
  output logic              xl_fault,
  output logic [ADDR_W-1:0] xl_fault_addr,
  output logic [7:0]        fault_vec
);
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  walk_state_e state;
  logic take_req, take_pde, take_pte, take_fault;
  logic walk_idle, walk_dir, walk_tbl;
  logic [OFF_W+OFF_W-2:0] unused_bits;

  assign unused_bits = {dir_base[OFF_W-1:0], mem_rdata[OFF_W-1:1]};

  ptw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .pg_en      (pg_en),
    .mem_ack    (mem_ack),
    .ent_present(mem_rdata[PRESENT_BIT]),
    .state      (state),
    .take_req   (take_req),
    .take_pde   (take_pde),
    .take_pte   (take_pte),
    .take_fault (take_fault)
  );

  assign walk_idle = (state == ST_IDLE);
  assign walk_dir  = (state == ST_DIR);
  assign walk_tbl  = (state == ST_TBL);

  ptw_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_lin   (req_lin),
    .base_frame(dir_base[ADDR_W-1:OFF_W]),
    .rd_frame  (mem_rdata[ADDR_W-1:ADDR_W-FRAME_W]),
    .pg_en     (pg_en),
    .take_req  (take_req),
    .take_pde  (take_pde),
    .take_pte  (take_pte),
    .take_fault(take_fault),
    .sel_tbl   (walk_tbl),
    .rd_addr   (mem_addr),
    .phys      (xl_phys),
    .flt_addr  (xl_fault_addr)
  );

  assign mem_req   = walk_dir || walk_tbl;
  assign xl_done   = (state == ST_DONE);
  assign xl_fault  = (state == ST_FAULT);
  assign fault_vec = xl_fault ? PF_VECTOR : 8'd0;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_lin,
  input logic              pg_en,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_rdata,
  input logic              xl_done,
  input logic [ADDR_W-1:0] xl_phys,
  input logic              xl_fault,
  input logic [7:0]        fault_vec,
  input logic              walk_idle,
  input logic              walk_dir,
  input logic              walk_tbl
);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    walk_idle && req_valid && !pg_en |=> xl_done && !mem_req && xl_phys == $past(req_lin));

  p_pde_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_dir && mem_ack && !mem_rdata[0] |=> xl_fault && !mem_req);

  p_pte_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_tbl && mem_ack && mem_rdata[0] |=>
      xl_done && xl_phys[ADDR_W-1:OFF_W] == $past(mem_rdata[ADDR_W-1:OFF_W]));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done |=> !xl_done);

  p_fault_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |=> !xl_fault);

  p_fault_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> fault_vec == 8'd14 && !xl_done);

  p_quiet_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_fault |-> fault_vec == 8'd0);
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_lin  (req_lin),
  .pg_en    (pg_en),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .mem_rdata(mem_rdata),
  .xl_done  (xl_done),
  .xl_phys  (xl_phys),
  .xl_fault (xl_fault),
  .fault_vec(fault_vec),
  .walk_idle(walk_idle),
  .walk_dir (walk_dir),
  .walk_tbl (walk_tbl)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  localparam logic [31:0] DIRB = 32'h0012_3ABC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_lin = '0;
  logic        pg_en = 1'b0;
  logic [31:0] dir_base = DIRB;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        xl_done;
  logic [31:0] xl_phys;
  logic        xl_fault;
  logic [31:0] xl_fault_addr;
  logic [7:0]  fault_vec;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int rd_total = 0;
  int done_cnt = 0;
  int fault_cnt = 0;
  logic [31:0] rd_log [0:7];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .pg_en(pg_en), .dir_base(dir_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xl_done(xl_done), .xl_phys(xl_phys),
    .xl_fault(xl_fault), .xl_fault_addr(xl_fault_addr), .fault_vec(fault_vec)
  );

  // Directory contents: entries whose index is 3 mod 4 are absent
  function automatic logic [31:0] pde_of(input logic [9:0] i);
    logic [19:0] fr;
    fr = 20'h40000 | {10'd0, i};
    return {fr, 11'((i * 3) ^ 11'h2AA), ((i % 4) != 3)};
  endfunction

  // Table contents, computed from table frame and index
  function automatic logic [31:0] pte_of(input logic [9:0] i, input logic [9:0] j);
    logic [19:0] fr;
    fr = 20'((i * 613 + j * 97) ^ 20'hA5000);
    return {fr, 11'({1'b0, j} ^ 11'h555), (((i + j) % 5) != 2)};
  endfunction

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    if (a[31:12] == DIRB[31:12]) return pde_of(a[11:2]);
    return pte_of(a[21:12], a[11:2]);
  endfunction

  // Memory model with programmable wait cycles
  int wcnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= 32'hFFFF_FFFE;
      wcnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack <= 1'b1;
        mem_rdata <= mem_fn(mem_addr);
        rd_log[rd_total % 8] <= mem_addr;
        rd_total <= rd_total + 1;
        wcnt <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
      mem_rdata <= 32'hFFFF_FFFE;
    end
  end

  always @(posedge clk) begin
    if (rst_n && xl_done) done_cnt <= done_cnt + 1;
    if (rst_n && xl_fault) fault_cnt <= fault_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One translation; disturb changes inputs while the walk runs
  task automatic walk(input logic [31:0] lin, input bit pg, input bit disturb);
    logic [9:0]  i, j;
    logic [31:0] a0, a1, pde, pte, exp_phys;
    bit exp_fault;
    int exp_reads, r0, d0, f0, n;
    bit seen;
    i = lin[31:22];
    j = lin[21:12];
    a0 = {DIRB[31:12], i, 2'b00};
    pde = pde_of(i);
    a1 = {pde[31:12], j, 2'b00};
    pte = mem_fn(a1);
    if (!pg) begin
      exp_reads = 0; exp_fault = 0; exp_phys = lin;
    end else if (!pde[0]) begin
      exp_reads = 1; exp_fault = 1; exp_phys = 32'h0;
    end else if (!pte[0]) begin
      exp_reads = 2; exp_fault = 1; exp_phys = 32'h0;
    end else begin
      exp_reads = 2; exp_fault = 0; exp_phys = {pte[31:12], lin[11:0]};
    end
    r0 = rd_total; d0 = done_cnt; f0 = fault_cnt;
    req_valid = 1'b1; req_lin = lin; pg_en = pg;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 1'b0;
    n = 0;
    while (!seen && n < 100) begin
      if (xl_done || xl_fault) seen = 1'b1;
      else begin
        if (disturb) begin
          // R9: busy-time request, base and mode changes must be ignored
          req_valid = 1'b1; req_lin = ~lin; pg_en = ~pg; dir_base = 32'hDEAD_0000;
        end
        @(negedge clk);
        n++;
      end
    end
    req_valid = 1'b0; req_lin = lin; pg_en = pg; dir_base = DIRB;
    chk(seen, "R10 completion", {31'd0, seen}, 32'd1);
    if (!seen) return;
    chk(xl_fault == exp_fault && xl_done == !exp_fault, exp_fault ? "R4/R5 fault raised" : "R3 done raised",
        {30'd0, xl_fault, xl_done}, {30'd0, exp_fault, !exp_fault});
    if (exp_fault) begin
      chk(xl_fault_addr == lin, "R7 fault address", xl_fault_addr, lin);
      chk(fault_vec == 8'd14, "R7 fault vector", {24'd0, fault_vec}, 32'd14);
    end else begin
      chk(xl_phys == exp_phys, pg ? "R3 physical address" : "R6 pass-through", xl_phys, exp_phys);
      chk(fault_vec == 8'd0, "R7 vector idle", {24'd0, fault_vec}, 32'd0);
    end
    chk(rd_total - r0 == exp_reads, exp_reads == 1 ? "R4 read count" : (pg ? "R5 read count" : "R6 no reads"),
        32'(rd_total - r0), 32'(exp_reads));
    if (exp_reads >= 1) chk(rd_log[r0 % 8] == a0, "R1 directory address", rd_log[r0 % 8], a0);
    if (exp_reads == 2) chk(rd_log[(r0 + 1) % 8] == a1, "R2 table address", rd_log[(r0 + 1) % 8], a1);
    repeat (3) @(negedge clk);
    chk(!xl_done && !xl_fault, "R10 strobes one cycle", {30'd0, xl_done, xl_fault}, 32'd0);
    chk((done_cnt - d0) + (fault_cnt - f0) == 1, "R10 single completion",
        32'((done_cnt - d0) + (fault_cnt - f0)), 32'd1);
    if (exp_fault) chk(xl_fault_addr == lin, "R10 fault address held", xl_fault_addr, lin);
    else           chk(xl_phys == exp_phys, "R10 physical held", xl_phys, exp_phys);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    chk(!mem_req && !xl_done && !xl_fault && fault_vec == 0, "R11 reset strobes",
        {28'd0, mem_req, xl_done, xl_fault, |fault_vec}, 32'd0);
    chk(xl_phys == 0 && xl_fault_addr == 0, "R11 reset addresses", xl_phys | xl_fault_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Corner walks: lowest and highest indices and offsets
    lat = 0;
    walk(32'h0000_0000, 1'b1, 1'b0);
    walk(32'hFFFF_FFFF, 1'b1, 1'b0);
    walk(32'h0040_0FFF, 1'b1, 1'b0);
    walk(32'hFF80_1000, 1'b1, 1'b0);
    walk(32'hFFFF_FFFF, 1'b0, 1'b0);
    walk(32'h0000_0000, 1'b0, 1'b0);

    // Sweep over indices, offsets and memory latency
    for (int k = 0; k < 128; k++) begin
      logic [31:0] l;
      l = {10'(k * 97 + k / 16), 10'(k * 53 + 1), 12'(k * 71)};
      lat = k % 4;
      walk(l, 1'b1, 1'b0);
    end

    // Pass-through sweep (R6)
    for (int k = 0; k < 16; k++) begin
      walk(32'(k * 32'h1357_9BDF), 1'b0, 1'b0);
    end

    // Inputs disturbed while busy (R9)
    for (int k = 0; k < 24; k++) begin
      logic [31:0] l;
      l = {10'(k * 41 + 2), 10'(k * 29 + 5), 12'(k * 173)};
      lat = (k % 3) + 1;
      walk(l, 1'b1, 1'b1);
    end

    report();
  end
endmodule